// File: doc/BRIEF.md
# Standby Mode Entry and Exit Controller

This block decides when a power converter drops into its near-zero-consumption idle state and when it comes back. Two active-low request pins feed it: one asks for idle, the other asks for wake-up. Each pin first passes through a two-flop synchronizer. Each then has its own debounce counter, which advances once per reference tick. The counters only advance while their pin is low and only in the mode where that pin matters. Idle is entered after a long, uninterrupted low on the enter pin. Idle is left after a much shorter uninterrupted low on the wake pin.

In normal mode the block allows switching. In idle mode it stops switching, tells the startup charger to hold the supply at its idle level instead of recharging in hysteresis, and gates off every circuit not needed to detect the wake request. Leaving idle raises a one-cycle pulse that starts a fresh soft-start. The idle state is not retained across a power loss: reset always brings the block up in normal mode. Both windows are parameters counted in reference ticks.

Top module: `stby_ctrl`

## Requirements
- R1: Idle is entered on the clock edge that samples the ENTER_TICKS-th reference tick during which the synchronized enter pin has been continuously low; fewer ticks leave the block in normal mode.
- R2: Idle is left on the clock edge that samples the WAKE_TICKS-th reference tick during which the synchronized wake pin has been continuously low while idle; fewer ticks leave the block idle.
- R3: A high level on a request pin, seen after synchronization, before its window completes clears that pin's tick count, so a later low period counts from zero.
- R4: In normal mode sw_en_o=1, supply_hold_o=0 and aux_off_o=0; in idle mode sw_en_o=0, supply_hold_o=1 and aux_off_o=1.
- R5: While idle, the enter pin has no effect, however long it is held low.
- R6: While in normal mode, the wake pin has no effect and its count is held at zero, so after idle entry a wake needs a full WAKE_TICKS ticks even if the pin was already low.
- R7: Leaving idle drives softstart_o high for exactly one clock cycle, the first cycle in which sw_en_o is 1 again.
- R8: While rst_n is low at a clock edge, the block goes to normal mode with softstart_o=0, whatever state it was in.
- R9: Clock cycles without a reference tick do not advance either debounce count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset; models power loss |
| tick_i | input | 1 | One-cycle reference tick that paces both debounce windows |
| enter_req_n_i | input | 1 | Active-low request to enter idle (asynchronous) |
| wake_req_n_i | input | 1 | Active-low request to leave idle (asynchronous) |
| sw_en_o | output | 1 | 1 allows converter switching |
| supply_hold_o | output | 1 | 1 tells the startup charger to hold the supply at its idle level |
| aux_off_o | output | 1 | 1 gates off non-essential circuitry |
| softstart_o | output | 1 | One-cycle pulse that starts a soft-start on wake-up |

## Verification
The hardest case to reach from the ports is a wake pin that is already low at the moment idle is entered. Only this case shows whether the wake count was really held at zero in normal mode or had quietly built up. The stimulus holds both pins low through a full entry window, so the wake pin sees more ticks than its own window before idle begins. It then checks that the block stays idle until WAKE_TICKS further ticks have passed. Tick counts on both pins are also swept one by one up to the boundary, with releases in between, to show the exact edge at which each transition happens and that releases clear the counts.

// File: rtl/stby_pkg.sv
// Package: shared mode type for the standby controller.
package stby_pkg;
    typedef enum logic {
        MODE_RUN  = 1'b0,
        MODE_IDLE = 1'b1
    } stby_mode_e;
endpackage

// File: rtl/stby_sync.sv
// Module: stby_sync
// Brings W asynchronous active-low pins into the clock domain through
// STAGES flops per bit. Assumes pins rest high, so reset loads ones.
module stby_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_n_i,
    output logic [W-1:0] pin_n_o
);
    genvar b;
    generate
        for (b = 0; b < W; b++) begin : g_bit
            logic [STAGES-1:0] chain_q;
            // Shift the pin level through the synchronizer chain.
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '1;
                else        chain_q <= {chain_q[STAGES-2:0], pin_n_i[b]};
            end
            assign pin_n_o[b] = chain_q[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/stby_debounce.sv
// Module: stby_debounce
// Counts reference ticks while the request is low and the channel is
// armed; done_o is high in the cycle of the WINDOW-th such tick.
// Assumes WINDOW >= 1 and single-cycle ticks.
module stby_debounce #(
    parameter int WINDOW = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic arm_i,
    input  logic req_low_i,
    output logic done_o
);
    localparam int CW = (WINDOW < 2) ? 1 : $clog2(WINDOW);
    localparam logic [CW-1:0] LAST = CW'(WINDOW - 1);

    logic [CW-1:0] cnt_q;
    logic          active;

    assign active = arm_i && req_low_i;

    // Advance on ticks while active, clear on release or disarm.
    always_ff @(posedge clk) begin
        if (!rst_n)                  cnt_q <= '0;
        else if (!active)            cnt_q <= '0;
        else if (tick_i) begin
            if (cnt_q == LAST)       cnt_q <= '0;
            else                     cnt_q <= cnt_q + 1'b1;
        end
    end

    // Window completes on the tick that would pass the last count.
    assign done_o = active && tick_i && (cnt_q == LAST);
endmodule

// File: rtl/stby_fsm.sv
// Module: stby_fsm
// Two-mode controller: run <-> idle on debounced requests. Emits a
// one-cycle soft-start pulse on wake. Reset (power loss) forces run.
module stby_fsm
    import stby_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enter_done_i,
    input  logic wake_done_i,
    output logic idle_o,
    output logic softstart_o
);
    stby_mode_e mode_q;
    logic       ss_q;

    // Mode register and wake pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_RUN;
            ss_q   <= 1'b0;
        end else begin
            ss_q <= 1'b0;
            case (mode_q)
                MODE_RUN:  if (enter_done_i) mode_q <= MODE_IDLE;
                MODE_IDLE: if (wake_done_i) begin
                    mode_q <= MODE_RUN;
                    ss_q   <= 1'b1;
                end
                default:   mode_q <= MODE_RUN;
            endcase
        end
    end

    assign idle_o      = (mode_q == MODE_IDLE);
    assign softstart_o = ss_q;
endmodule

// File: rtl/stby_ctrl.sv
// Module: stby_ctrl (top)
// Standby entry/exit controller. Enter channel is armed only in run
// mode, wake channel only in idle mode. Assumes tick_i is one cycle wide.
module stby_ctrl #(
    parameter int ENTER_TICKS = 10000,
    parameter int WAKE_TICKS  = 20,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic enter_req_n_i,
    input  logic wake_req_n_i,
    output logic sw_en_o,
    output logic supply_hold_o,
    output logic aux_off_o,
    output logic softstart_o
);
    localparam int NPIN = 2;
    localparam int IDX_ENTER = 0;
    localparam int IDX_WAKE  = 1;

    logic [NPIN-1:0] pins_n_s;
    logic            enter_low, wake_low;
    logic            enter_done, wake_done;
    logic            idle;

    stby_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_n_i ({wake_req_n_i, enter_req_n_i}),
        .pin_n_o (pins_n_s)
    );

    assign enter_low = !pins_n_s[IDX_ENTER];
    assign wake_low  = !pins_n_s[IDX_WAKE];

    stby_debounce #(.WINDOW(ENTER_TICKS)) enter_db_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick_i),
        .arm_i     (!idle),
        .req_low_i (enter_low),
        .done_o    (enter_done)
    );

    stby_debounce #(.WINDOW(WAKE_TICKS)) wake_db_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick_i),
        .arm_i     (idle),
        .req_low_i (wake_low),
        .done_o    (wake_done)
    );

    stby_fsm fsm_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .enter_done_i (enter_done),
        .wake_done_i  (wake_done),
        .idle_o       (idle),
        .softstart_o  (softstart_o)
    );

    assign sw_en_o       = !idle;
    assign supply_hold_o = idle;
    assign aux_off_o     = idle;
endmodule

// File: rtl/stby_ctrl_chk.sv
// Module: stby_ctrl_chk
// Property checker for stby_ctrl, attached by bind below.
module stby_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic tick_i,
    input logic enter_low,
    input logic wake_low,
    input logic sw_en_o,
    input logic supply_hold_o,
    input logic aux_off_o,
    input logic softstart_o
);
    logic rst_prev_low = 1'b0;

    // Remember whether reset was applied at the previous edge.
    always_ff @(posedge clk) rst_prev_low <= !rst_n;

    // R8: first cycle after a reset edge is run mode, no pulse.
    always_ff @(posedge clk) begin
        if (rst_prev_low && rst_n)
            a_r8_reset_to_run: assert (sw_en_o && !softstart_o);
    end

    a_r4_output_modes: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_en_o != supply_hold_o) && (supply_hold_o == aux_off_o));

    a_r1_entry_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(supply_hold_o) |-> $past(enter_low && tick_i));

    a_r2_exit_needs_wake: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(supply_hold_o) |-> $past(wake_low && tick_i));

    a_r7_pulse_on_wake: assert property (@(posedge clk) disable iff (!rst_n)
        softstart_o |-> (sw_en_o && $fell(supply_hold_o)));

    a_r7_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
        softstart_o |=> !softstart_o);
endmodule

bind stby_ctrl stby_ctrl_chk chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .tick_i        (tick_i),
    .enter_low     (enter_low),
    .wake_low      (wake_low),
    .sw_en_o       (sw_en_o),
    .supply_hold_o (supply_hold_o),
    .aux_off_o     (aux_off_o),
    .softstart_o   (softstart_o)
);

// File: tb/stby_ctrl_tb_top.sv
// Bench for stby_ctrl with shortened windows; tick counts are swept.
module stby_ctrl_tb_top;
    localparam int ENTER = 6;
    localparam int WAKE  = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic enter_n = 1'b1;
    logic wake_n = 1'b1;
    logic sw_en, hold, aux_off, ss;
    int   n_checks = 0;
    int   n_fail   = 0;
    bit   finished = 1'b0;

    always #10 clk = ~clk;

    stby_ctrl #(.ENTER_TICKS(ENTER), .WAKE_TICKS(WAKE)) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .tick_i        (tick),
        .enter_req_n_i (enter_n),
        .wake_req_n_i  (wake_n),
        .sw_en_o       (sw_en),
        .supply_hold_o (hold),
        .aux_off_o     (aux_off),
        .softstart_o   (ss)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Checks the mode outputs: idle=1 expects 0/1/1, idle=0 expects 1/0/0.
    task automatic check_mode(input bit idle, input string tag);
        int act = {sw_en, hold, aux_off};
        int exp = idle ? 3'b011 : 3'b100;
        check(act == exp, tag, act, exp);
    endtask

    task automatic set_pins(input bit e, input bit w);
        @(negedge clk);
        enter_n = e;
        wake_n  = w;
        repeat (3) @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) tick = 1'b1;
            @(negedge clk) tick = 1'b0;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_mode(1'b0, "R8 reset state");
        check(ss == 1'b0, "R8 no pulse after reset", ss, 0);

        // R1/R3: every short low period leaves run mode, release clears count.
        for (int n = 1; n < ENTER; n++) begin
            set_pins(1'b0, 1'b1);
            ticks(n);
            check_mode(1'b0, "R1 short enter window");
            set_pins(1'b1, 1'b1);
        end
        // R3: two back-to-back partial windows never add up.
        set_pins(1'b0, 1'b1);
        ticks(ENTER - 1);
        set_pins(1'b1, 1'b1);
        set_pins(1'b0, 1'b0);   // wake also low: must be ignored (R6)
        ticks(ENTER - 1);
        check_mode(1'b0, "R3 count restarted after release");
        // R9: no ticks, no progress.
        repeat (20) @(negedge clk);
        check_mode(1'b0, "R9 no tick no entry");
        ticks(1);
        check_mode(1'b1, "R1 entry on final tick");
        check(ss == 1'b0, "R1 no pulse on entry", ss, 0);

        // R6: wake was low for more than WAKE ticks in run mode, yet counts from zero.
        ticks(WAKE - 1);
        check_mode(1'b1, "R6 wake count started at idle entry");
        set_pins(1'b0, 1'b1);

        // R5: enter pin held low and re-pulsed while idle.
        ticks(ENTER + 2);
        check_mode(1'b1, "R5 enter ignored while idle");
        set_pins(1'b1, 1'b1);
        set_pins(1'b0, 1'b1);
        ticks(ENTER);
        check_mode(1'b1, "R5 second enter ignored while idle");
        set_pins(1'b1, 1'b1);

        // R2/R3: short wake windows stay idle.
        for (int n = 1; n < WAKE; n++) begin
            set_pins(1'b1, 1'b0);
            ticks(n);
            check_mode(1'b1, "R2 short wake window");
            set_pins(1'b1, 1'b1);
        end
        set_pins(1'b1, 1'b0);
        ticks(WAKE - 1);
        repeat (10) @(negedge clk);
        check_mode(1'b1, "R9 no tick no wake");
        ticks(1);
        check_mode(1'b0, "R2 wake on final tick");
        check(ss == 1'b1, "R7 soft-start pulse", ss, 1);
        @(negedge clk);
        check(ss == 1'b0, "R7 pulse one cycle", ss, 0);
        set_pins(1'b1, 1'b1);

        // R8: reset while idle returns to run mode.
        set_pins(1'b0, 1'b1);
        ticks(ENTER);
        check_mode(1'b1, "R1 re-entry");
        set_pins(1'b1, 1'b1);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check_mode(1'b0, "R8 reset during idle");
        rst_n = 1'b1;
        @(negedge clk);
        check_mode(1'b0, "R8 run after reset release");
        check(ss == 1'b0, "R8 no pulse on reset", ss, 0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule